// File: doc/BRIEF.md
# DMA Pointer List Generator

The generator takes one transfer request and turns it into the sequence of 64-bit command words that a DMA command queue consumes. A request carries a transfer type, a source-side base address, a destination-side base address, a byte count and a template header word. The block first walks both pointer lists without emitting anything, to count their segments and words. It then sends the header, with the two segment counts written into it, followed by the first-side pointer list and the last-side pointer list. Words leave on a valid/ready stream.

There are two pointer encodings. A local-memory list spends one word per chunk, and each chunk covers at most 8191 bytes. A bus-side list cuts the transfer into segments of at most 65535 bytes and groups them by four: a single word holding four 16-bit lengths comes first, then the address words of that group. The total command word count is reported so that a doorbell can be rung. An optional restricted mode refuses requests whose counts are too large. Any request whose command would exceed the word cap is also refused. A refused request emits no words.

Top module: `dma_ptr_gen`

## Requirements
- R1: The first word out is the header template with bits [5:0] replaced by the first-list segment count and bits [11:6] replaced by the last-list segment count. All other header bits are unchanged.
- R2: A local-encoded list splits the size into chunks of at most 8191 bytes, in order. Each chunk gives one word with the chunk length in bits [60:48], bits [47:0] of the chunk start address in bits [47:0], and zero in bits [63:61]. Each chunk starts where the previous one ended.
- R3: A bus-encoded list splits the size into segments of at most 65535 bytes. They are sent in groups of up to four. Each group starts with a length word that holds segment i of the group in bits [16i+15:16i], with zero in slots past the final segment. The group's 64-bit segment start addresses follow. Every segment except the last of the list is exactly 65535 bytes.
- R4: A bus-encoded list of N segments takes N + (N-1)/4 + 1 words.
- R5: The transfer type selects the encodings. 0 is local/local, 1 and 2 are local first and bus last, and 3 is bus/bus.
- R6: A size of zero produces no pointer words, and both counts in the header are zero.
- R7: When restricted mode is set, a request is refused (err_strict=1, no words) if the first count exceeds 11, the last count exceeds 11, or their sum exceeds 15.
- R8: cmd_words reports 1 plus the word counts of both lists. It is valid from done until the next start.
- R9: A request whose cmd_words would exceed 32 is refused with err_overflow=1, and no word is emitted.
- R10: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged.
- R11: done is high for exactly one cycle. For an accepted request, that is the cycle after the last word is accepted. done is never high together with out_valid.
- R12: After reset, out_valid, done, both error flags and cmd_words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| xfer_type | input | 2 | Transfer type, 0 to 3 |
| first_addr | input | 64 | Base address of the first list |
| last_addr | input | 64 | Base address of the last list |
| xfer_size | input | SIZE_W | Transfer size in bytes |
| hdr_in | input | 64 | Header template |
| strict | input | 1 | Restricted-mode enable |
| out_data | output | 64 | Command word |
| out_valid | output | 1 | Command word valid |
| out_ready | input | 1 | Consumer accepts the word |
| done | output | 1 | One-cycle completion pulse |
| err_strict | output | 1 | Refused by the restricted-mode limits |
| err_overflow | output | 1 | Refused because the word cap would be exceeded |
| cmd_words | output | SIZE_W-9 | Total command words for the doorbell |

## Verification
The assertions assume that start pulses only while the block is idle, and that out_ready may drop at any cycle, even mid-list. The stimulus issues a new request only after the previous done pulse. It drives out_ready with rotating stall patterns, so that header, local words and bus length words are each held under backpressure. Sizes are swept across every chunk and group boundary, under all four transfer types, with restricted mode both off and on.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
    localparam int WORD_W        = 64;
    localparam int LOC_CAP       = 8191;
    localparam int BUS_CAP       = 65535;
    localparam int LOC_ADDR_W    = 48;
    localparam int LOC_LEN_LSB   = 48;
    localparam int LOC_LEN_W     = 13;
    localparam int BUS_LEN_W     = 16;
    localparam int BUS_GROUP     = 4;
    localparam int HDR_CNT_W     = 6;
    localparam int HDR_FIRST_LSB = 0;
    localparam int HDR_LAST_LSB  = 6;
    localparam int STRICT_ONE    = 11;
    localparam int STRICT_SUM    = 15;

    typedef enum logic [1:0] {
        XFER_LOCAL    = 2'd0,
        XFER_INBOUND  = 2'd1,
        XFER_OUTBOUND = 2'd2,
        XFER_EXTERNAL = 2'd3
    } xfer_e;

    typedef enum logic {
        ENC_LOCAL = 1'b0,
        ENC_BUS   = 1'b1
    } enc_e;

    function automatic enc_e first_enc(xfer_e t);
        return (t == XFER_EXTERNAL) ? ENC_BUS : ENC_LOCAL;
    endfunction

    function automatic enc_e last_enc(xfer_e t);
        return (t == XFER_LOCAL) ? ENC_LOCAL : ENC_BUS;
    endfunction
endpackage

// File: rtl/dpl_walker.sv
module dpl_walker
    import dpl_pkg::*;
#(
    parameter int SIZE_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  enc_e              enc_i,
    input  logic [WORD_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              adv,
    output logic [WORD_W-1:0] word_o,
    output logic              seg_o,
    output logic              active_o,
    output logic              last_o
);
    localparam logic [SIZE_W-1:0] LCAP = SIZE_W'(LOC_CAP);
    localparam logic [SIZE_W-1:0] BCAP = SIZE_W'(BUS_CAP);

    logic [SIZE_W-1:0] rem;
    logic [WORD_W-1:0] cur;
    logic [2:0]        slot;
    enc_e              enc_q;
    logic [SIZE_W-1:0] cap;
    logic [SIZE_W-1:0] take;
    logic [WORD_W-1:0] lens_word;

    assign cap  = (enc_q == ENC_BUS) ? BCAP : LCAP;
    assign take = (rem > cap) ? cap : rem;

    for (genvar g = 0; g < BUS_GROUP; g++) begin : g_len
        localparam logic [SIZE_W-1:0] OFF = SIZE_W'(g * BUS_CAP);
        logic [SIZE_W-1:0] left;
        assign left = (rem > OFF) ? (rem - OFF) : '0;
        assign lens_word[g*BUS_LEN_W +: BUS_LEN_W] =
            (left > BCAP) ? {BUS_LEN_W{1'b1}} : left[BUS_LEN_W-1:0];
    end

    assign seg_o    = (enc_q == ENC_LOCAL) || (slot != 3'd0);
    assign active_o = (rem != '0);
    assign last_o   = active_o && seg_o && (rem <= cap);

    always_comb begin
        word_o = '0;
        if (enc_q == ENC_LOCAL) begin
            word_o[LOC_ADDR_W-1:0] = cur[LOC_ADDR_W-1:0];
            word_o[LOC_LEN_LSB +: LOC_LEN_W] = take[LOC_LEN_W-1:0];
        end else if (slot == 3'd0) begin
            word_o = lens_word;
        end else begin
            word_o = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            cur   <= '0;
            slot  <= '0;
            enc_q <= ENC_LOCAL;
        end else if (load) begin
            rem   <= size_i;
            cur   <= base_i;
            slot  <= '0;
            enc_q <= enc_i;
        end else if (adv && active_o) begin
            if (seg_o) begin
                cur <= cur + WORD_W'(take);
                rem <= rem - take;
            end
            if (enc_q == ENC_BUS) begin
                if (slot == 3'd0)                 slot <= 3'd1;
                else if (slot == 3'(BUS_GROUP))   slot <= 3'd0;
                else                              slot <= slot + 3'd1;
            end
        end
    end
endmodule

// File: rtl/dpl_judge.sv
module dpl_judge
    import dpl_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int TOT_W     = 11,
    parameter int MAX_WORDS = 32
) (
    input  logic [CNT_W-1:0] n_first,
    input  logic [CNT_W-1:0] n_last,
    input  logic [TOT_W-1:0] w_first,
    input  logic [TOT_W-1:0] w_last,
    input  logic             strict,
    output logic [TOT_W-1:0] total,
    output logic             err_strict,
    output logic             err_over
);
    logic [CNT_W:0] n_sum;

    assign n_sum      = {1'b0, n_first} + {1'b0, n_last};
    assign total      = TOT_W'(1) + w_first + w_last;
    assign err_strict = strict && ((n_first > CNT_W'(STRICT_ONE)) ||
                                   (n_last  > CNT_W'(STRICT_ONE)) ||
                                   (n_sum   > (CNT_W+1)'(STRICT_SUM)));
    assign err_over   = (total > TOT_W'(MAX_WORDS));
endmodule

// File: rtl/dma_ptr_gen.sv
module dma_ptr_gen
    import dpl_pkg::*;
#(
    parameter int SIZE_W    = 20,
    parameter int MAX_WORDS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          xfer_type,
    input  logic [63:0]         first_addr,
    input  logic [63:0]         last_addr,
    input  logic [SIZE_W-1:0]   xfer_size,
    input  logic [63:0]         hdr_in,
    input  logic                strict,
    output logic [63:0]         out_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                done,
    output logic                err_strict,
    output logic                err_overflow,
    output logic [SIZE_W-10:0]  cmd_words
);
    localparam int CNT_W = SIZE_W - 11;
    localparam int TOT_W = CNT_W + 2;

    typedef enum logic [2:0] {
        S_IDLE, S_COUNT, S_JUDGE, S_HDR, S_FIRST, S_LAST, S_FIN
    } st_e;

    st_e               st;
    xfer_e             type_q;
    logic [63:0]       fa_q, la_q, hdr_q;
    logic [SIZE_W-1:0] size_q;
    logic              strict_q;
    logic [CNT_W-1:0]  n1, n2;
    logic [TOT_W-1:0]  w1, w2;

    logic              ld, adv_f, adv_l;
    logic [63:0]       f_base, l_base;
    logic [SIZE_W-1:0] ld_size;
    enc_e              f_enc, l_enc;
    logic [63:0]       f_word, l_word;
    logic              f_seg, l_seg, f_act, l_act, f_last, l_last;
    logic [TOT_W-1:0]  j_total;
    logic              j_es, j_eo, j_err;
    logic [63:0]       hdr_word;

    assign j_err = j_es | j_eo;
    assign ld    = (st == S_IDLE && start) || (st == S_JUDGE && !j_err);
    assign adv_f = (st == S_COUNT) || (st == S_FIRST && out_ready);
    assign adv_l = (st == S_COUNT) || (st == S_LAST && out_ready);

    always_comb begin
        if (st == S_IDLE) begin
            f_base  = first_addr;
            l_base  = last_addr;
            ld_size = xfer_size;
            f_enc   = first_enc(xfer_e'(xfer_type));
            l_enc   = last_enc(xfer_e'(xfer_type));
        end else begin
            f_base  = fa_q;
            l_base  = la_q;
            ld_size = size_q;
            f_enc   = first_enc(type_q);
            l_enc   = last_enc(type_q);
        end
    end

    dpl_walker #(.SIZE_W(SIZE_W)) u_first (
        .clk(clk), .rst(rst), .load(ld), .enc_i(f_enc), .base_i(f_base),
        .size_i(ld_size), .adv(adv_f), .word_o(f_word), .seg_o(f_seg),
        .active_o(f_act), .last_o(f_last)
    );

    dpl_walker #(.SIZE_W(SIZE_W)) u_last (
        .clk(clk), .rst(rst), .load(ld), .enc_i(l_enc), .base_i(l_base),
        .size_i(ld_size), .adv(adv_l), .word_o(l_word), .seg_o(l_seg),
        .active_o(l_act), .last_o(l_last)
    );

    dpl_judge #(.CNT_W(CNT_W), .TOT_W(TOT_W), .MAX_WORDS(MAX_WORDS)) u_judge (
        .n_first(n1), .n_last(n2), .w_first(w1), .w_last(w2), .strict(strict_q),
        .total(j_total), .err_strict(j_es), .err_over(j_eo)
    );

    always_comb begin
        hdr_word = hdr_q;
        hdr_word[HDR_FIRST_LSB +: HDR_CNT_W] = n1[HDR_CNT_W-1:0];
        hdr_word[HDR_LAST_LSB  +: HDR_CNT_W] = n2[HDR_CNT_W-1:0];
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        case (st)
            S_HDR:   begin out_valid = 1'b1; out_data = hdr_word; end
            S_FIRST: begin out_valid = 1'b1; out_data = f_word;   end
            S_LAST:  begin out_valid = 1'b1; out_data = l_word;   end
            default: ;
        endcase
    end

    assign done = (st == S_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            type_q       <= XFER_LOCAL;
            fa_q         <= '0;
            la_q         <= '0;
            hdr_q        <= '0;
            size_q       <= '0;
            strict_q     <= 1'b0;
            n1           <= '0;
            n2           <= '0;
            w1           <= '0;
            w2           <= '0;
            err_strict   <= 1'b0;
            err_overflow <= 1'b0;
            cmd_words    <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    type_q       <= xfer_e'(xfer_type);
                    fa_q         <= first_addr;
                    la_q         <= last_addr;
                    hdr_q        <= hdr_in;
                    size_q       <= xfer_size;
                    strict_q     <= strict;
                    n1           <= '0;
                    n2           <= '0;
                    w1           <= '0;
                    w2           <= '0;
                    err_strict   <= 1'b0;
                    err_overflow <= 1'b0;
                    cmd_words    <= '0;
                    st           <= S_COUNT;
                end
                S_COUNT: begin
                    if (f_act) begin
                        w1 <= w1 + TOT_W'(1);
                        if (f_seg) n1 <= n1 + CNT_W'(1);
                    end
                    if (l_act) begin
                        w2 <= w2 + TOT_W'(1);
                        if (l_seg) n2 <= n2 + CNT_W'(1);
                    end
                    if (!f_act && !l_act) st <= S_JUDGE;
                end
                S_JUDGE: begin
                    err_strict   <= j_es;
                    err_overflow <= j_eo;
                    cmd_words    <= j_total;
                    st           <= j_err ? S_FIN : S_HDR;
                end
                S_HDR: if (out_ready)
                    st <= f_act ? S_FIRST : (l_act ? S_LAST : S_FIN);
                S_FIRST: if (out_ready && f_last)
                    st <= l_act ? S_LAST : S_FIN;
                S_LAST: if (out_ready && l_last)
                    st <= S_FIN;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_ptr_gen_chk.sv
module dma_ptr_gen_chk #(
    parameter int TOT_W     = 11,
    parameter int MAX_WORDS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [63:0]      out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             done,
    input logic             err_strict,
    input logic             err_overflow,
    input logic [TOT_W-1:0] cmd_words
);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R9
    err_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (err_strict || err_overflow) |-> !out_valid);

    // R8
    words_cap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cmd_words != '0) && (cmd_words <= TOT_W'(MAX_WORDS)));
endmodule

bind dma_ptr_gen dma_ptr_gen_chk #(.TOT_W(SIZE_W - 9), .MAX_WORDS(MAX_WORDS)) u_chk (
    .clk(clk), .rst(rst), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .err_strict(err_strict),
    .err_overflow(err_overflow), .cmd_words(cmd_words)
);

// File: tb/dma_ptr_gen_tb.sv
module dma_ptr_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SIZE_W     = 20;
    localparam int TOT_W      = SIZE_W - 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        xfer_type = '0;
    logic [63:0]       first_addr = '0, last_addr = '0, hdr_in = '0;
    logic [SIZE_W-1:0] xfer_size = '0;
    logic              strict = 1'b0;
    logic [63:0]       out_data;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic              done, err_strict, err_overflow;
    logic [TOT_W-1:0]  cmd_words;

    int n_chk = 0;
    int n_bad = 0;
    longint exp_w [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_ptr_gen #(.SIZE_W(SIZE_W), .MAX_WORDS(32)) u_dut (
        .clk(clk), .rst(rst), .start(start), .xfer_type(xfer_type),
        .first_addr(first_addr), .last_addr(last_addr), .xfer_size(xfer_size),
        .hdr_in(hdr_in), .strict(strict), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .done(done),
        .err_strict(err_strict), .err_overflow(err_overflow),
        .cmd_words(cmd_words)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic longint nloc(longint s);  return (s + 8190) / 8191;   endfunction
    function automatic longint nbus(longint s);  return (s + 65534) / 65535; endfunction
    function automatic longint wbus(longint n);  return (n == 0) ? 0 : n + (n - 1) / 4 + 1; endfunction

    function automatic longint loc_word(longint base, longint s, longint k);
        longint chunk = s - k * 8191;
        longint a = base + k * 8191;
        if (chunk > 8191) chunk = 8191;
        return ((chunk & 64'h1FFF) << 48) | (a & 64'h0000_FFFF_FFFF_FFFF);
    endfunction

    function automatic longint bus_word(longint base, longint s, longint k);
        longint g = k / 5;
        longint p = k % 5;
        longint w = 0;
        if (p == 0) begin
            for (int i = 0; i < 4; i++) begin
                longint r = s - (4 * g + i) * 65535;
                if (r < 0) r = 0;
                if (r > 65535) r = 65535;
                w = w | (r << (16 * i));
            end
            return w;
        end
        return base + (4 * g + p - 1) * 65535;
    endfunction

    task automatic run_case(input int ty, input longint sz, input bit st_mode, input int stall);
        bit     f_bus = (ty == 3);
        bit     l_bus = (ty != 0);
        longint fa = 64'h0000_1234_5678_9000 + sz;
        longint la = 64'hFFFF_FFFF_FFFF_0010 - sz;
        longint hd = 64'hA5C3_0F0F_1234_5FFF ^ (sz << 20);
        longint n1 = f_bus ? nbus(sz) : nloc(sz);
        longint n2 = l_bus ? nbus(sz) : nloc(sz);
        longint w1 = f_bus ? wbus(n1) : n1;
        longint w2 = l_bus ? wbus(n2) : n2;
        longint tot = 1 + w1 + w2;
        bit es = st_mode && (n1 > 11 || n2 > 11 || n1 + n2 > 15);
        bit eo = (tot > 32);
        bit err = es || eo;
        int idx = 0;
        int dones = 0;
        bit prev_stall = 0;
        longint prev_data = 0;
        int cyc = 0;
        if (!err) begin
            // R1 header with counts overwritten, R5 encodings per type
            exp_w[0] = (hd & ~64'hFFF) | (n1 & 64'h3F) | ((n2 & 64'h3F) << 6);
            for (int k = 0; k < w1; k++)
                exp_w[1 + k] = f_bus ? bus_word(fa, sz, k) : loc_word(fa, sz, k);
            for (int k = 0; k < w2; k++)
                exp_w[1 + w1 + k] = l_bus ? bus_word(la, sz, k) : loc_word(la, sz, k);
        end
        @(negedge clk);
        xfer_type  = 2'(ty);
        xfer_size  = SIZE_W'(sz);
        first_addr = fa;
        last_addr  = la;
        hdr_in     = hd;
        strict     = st_mode;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (dones == 0 && cyc < 3000) begin
            out_ready = (stall == 0) ? 1'b1 : (((cyc + stall) % (stall + 2)) != 0);
            if (prev_stall) // R10
                chk(out_valid && out_data == prev_data, "R10 stall hold", out_data, prev_data);
            if (done) begin
                dones++;
                chk(!out_valid, "R11 done with valid", out_valid, 0);
            end else if (out_valid) begin
                if (err) chk(0, "R9 word emitted on refused request", out_data, 0);
                else if (idx < tot)
                    chk(out_data == exp_w[idx], (idx == 0) ? "R1 header" :
                        ((idx <= w1) ? (f_bus ? "R3 first list" : "R2 first list") :
                                       (l_bus ? "R3 last list"  : "R2 last list")),
                        out_data, exp_w[idx]);
                if (out_ready) idx++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            @(negedge clk);
            cyc++;
        end
        chk(dones == 1, "R11 done seen", dones, 1);
        chk(!done, "R11 done single cycle", done, 0);
        // R4 R6 word count emitted, R8 doorbell count
        chk(idx == (err ? 0 : tot), "R4 R6 words emitted", idx, err ? 0 : tot);
        chk(cmd_words == TOT_W'(tot), "R8 cmd_words", cmd_words, tot);
        chk(err_strict == es, "R7 restricted refusal", err_strict, es);
        chk(err_overflow == eo, "R9 overflow refusal", err_overflow, eo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint sizes [15] = '{0, 1, 8190, 8191, 8192, 20000, 65535, 65536, 98292,
                                131070, 131071, 196605, 262140, 262141, 300000};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!out_valid && !done, "R12 reset outputs", {out_valid, done}, 0);
        chk(!err_strict && !err_overflow && cmd_words == '0, "R12 reset flags",
            {err_strict, err_overflow, 12'(cmd_words)}, 0);
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 15; s++)
                for (int m = 0; m < 2; m++)
                    run_case(t, sizes[s], m[0], (s + t + m) % 4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule